// File: doc/BRIEF.md
# I2C Target Register Access Port

This block is an I2C target that gives an external host byte-wide access to a register table. The register table sits next to it in the chip. The block oversamples SCL and SDA with the system clock and follows the bus protocol: START, repeated START, STOP, address match, ACK and NACK. It drives a plain register-file port with an address, write data, a one-cycle write strobe and combinational read data.

A host first sends a write transfer. The first byte after the device address sets an internal 8-bit pointer. Any bytes after that are stored at the pointer, and the pointer steps forward after each byte. A read transfer carries no pointer of its own. It streams bytes from wherever the pointer stands and advances the pointer after each byte. The pointer keeps its value across STOP conditions, so a read that the host cut short can be picked up later where it stopped.

Top module: `rsp_i2c_regport`

## Requirements
- R1: The target answers only to the 7-bit address formed by the fixed bits 0001 in the upper four positions and strap_i[2:0] in the lower three. It ACKs that address in either direction. For any other address it gives no ACK, stores nothing and leaves the pointer unchanged until the next START.
- R2: In a write transfer, the byte after the address byte loads the pointer, is ACKed, and is not written to the register table.
- R3: Each later byte of a write transfer is ACKed and presented as a single-cycle reg_we_o pulse with reg_addr_o equal to the pointer. The pointer then advances by one.
- R4: In a read transfer, each byte is sent MSB first and comes from the register at the current pointer. The pointer advances by one for each byte loaded.
- R5: The pointer keeps its value across STOP. A new read transfer continues at the address after the last byte sent.
- R6: A host NACK after a read byte ends the stream. The target leaves SDA released until the next START or STOP, so further clocks read all ones.
- R7: A repeated START returns the target to the address phase, so a pointer write followed by a repeated START and a read returns data from the new pointer.
- R8: The pointer wraps from 0xFF to 0x00 for both writes and reads.
- R9: SDA is open-drain. The block has only a low-drive enable, sda_drive_low_o (1 = pull low), and that enable only turns on while SCL is low.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. STOP returns the target to idle with SDA released. After reset the target is idle with SDA released and no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_drive_low_o | output | 1 | 1 = pull SDA low, 0 = release |
| strap_i | input | 3 | Low three bits of the device address |
| reg_addr_o | output | PTR_W | Register-table address |
| reg_wdata_o | output | 8 | Register-table write data |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 8 | Register-table read data for reg_addr_o |

## Verification
The hardest case to reach is a pointer state left behind by an earlier transfer. This covers a read that the host ended with a NACK and then resumed in a fresh transfer, and a read that crosses the 0xFF to 0x00 boundary. The bench reaches these states only through the bus. It first sets the pointer with a write transfer, stops part-way through reads, clocks extra bytes after a NACK, and then starts new transfers. Every returned byte is compared against a model of the table and pointer kept in the bench. A sweep over all strap settings and all addresses in the device's upper-nibble range checks the address match.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_PTR,
        ST_WR,
        ST_RD,
        ST_RDACK
    } rsp_state_e;
endpackage

// File: rtl/rsp_line_sync.sv
module rsp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl      = {sync_q.scl[STAGES-2:0], scl_i};
        sync_d.sda      = {sync_q.sda[STAGES-2:0], sda_i};
        sync_d.scl_prev = sync_q.scl[STAGES-1];
        sync_d.sda_prev = sync_q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign scl_o      = sync_q.scl[STAGES-1];
    assign sda_o      = sync_q.sda[STAGES-1];
    assign scl_rise_o = scl_o & ~sync_q.scl_prev;
    assign scl_fall_o = ~scl_o & sync_q.scl_prev;
    assign start_o    = scl_o & sync_q.scl_prev & sync_q.sda_prev & ~sda_o;
    assign stop_o     = scl_o & sync_q.scl_prev & ~sync_q.sda_prev & sda_o;
endmodule

// File: rtl/rsp_ptr.sv
module rsp_ptr #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PTR_W-1:0] load_val_i,
    input  logic             inc_i,
    output logic [PTR_W-1:0] ptr_o
);
    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d = load_val_i;
        end else if (inc_i) begin
            ptr_d = ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o = ptr_q;

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && ptr_q == '1) |=> ptr_q == '0); // R8
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ptr_q == $past(load_val_i)); // R2
endmodule

// File: rtl/rsp_target_fsm.sv
module rsp_target_fsm
    import rsp_pkg::*;
#(
    parameter int          PTR_W  = 8,
    parameter logic [3:0]  DEV_HI = 4'b0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [PTR_W-1:0]   ptr_i,
    input  logic [BYTE_W-1:0]  rdata_i,
    output logic               sda_low_o,
    output logic               ptr_load_o,
    output logic [PTR_W-1:0]   ptr_load_val_o,
    output logic               ptr_inc_o,
    output logic               we_o,
    output logic [PTR_W-1:0]   waddr_o,
    output logic [BYTE_W-1:0]  wdata_o
);
    localparam int CNT_W = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        rsp_state_e        st;
        rsp_state_e        nxt;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              ackon;
        logic              hack;
        logic              low;
        logic              we;
        logic [PTR_W-1:0]  waddr;
        logic [BYTE_W-1:0] wdata;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [BYTE_W-1:0] sh_in;

    assign sh_in = {fsm_q.sh[BYTE_W-2:0], sda_i};

    always_comb begin
        fsm_d          = fsm_q;
        fsm_d.we       = 1'b0;
        ptr_load_o     = 1'b0;
        ptr_load_val_o = PTR_W'(sh_in);
        ptr_inc_o      = 1'b0;

        if (stop_i) begin
            fsm_d.st    = ST_IDLE;
            fsm_d.low   = 1'b0;
            fsm_d.ackon = 1'b0;
        end else if (start_i) begin
            fsm_d.st    = ST_ADDR;
            fsm_d.cnt   = '0;
            fsm_d.low   = 1'b0;
            fsm_d.ackon = 1'b0;
        end else begin
            unique case (fsm_q.st)
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        fsm_d.sh  = sh_in;
                        fsm_d.cnt = fsm_q.cnt + CNT_W'(1);
                        if (fsm_q.cnt == LAST_BIT) begin
                            if (sh_in[BYTE_W-1:1] == {DEV_HI, strap_i}) begin
                                fsm_d.st  = ST_ACK;
                                fsm_d.nxt = sh_in[0] ? ST_RD : ST_PTR;
                            end else begin
                                fsm_d.st = ST_IDLE;
                            end
                        end
                    end
                end
                ST_PTR: begin
                    if (scl_rise_i) begin
                        fsm_d.sh  = sh_in;
                        fsm_d.cnt = fsm_q.cnt + CNT_W'(1);
                        if (fsm_q.cnt == LAST_BIT) begin
                            ptr_load_o = 1'b1;
                            fsm_d.st   = ST_ACK;
                            fsm_d.nxt  = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise_i) begin
                        fsm_d.sh  = sh_in;
                        fsm_d.cnt = fsm_q.cnt + CNT_W'(1);
                        if (fsm_q.cnt == LAST_BIT) begin
                            fsm_d.we    = 1'b1;
                            fsm_d.waddr = ptr_i;
                            fsm_d.wdata = sh_in;
                            ptr_inc_o   = 1'b1;
                            fsm_d.st    = ST_ACK;
                            fsm_d.nxt   = ST_WR;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        if (!fsm_q.ackon) begin
                            fsm_d.low   = 1'b1;
                            fsm_d.ackon = 1'b1;
                        end else begin
                            fsm_d.low   = 1'b0;
                            fsm_d.ackon = 1'b0;
                            fsm_d.cnt   = '0;
                            fsm_d.st    = fsm_q.nxt;
                            if (fsm_q.nxt == ST_RD) begin
                                fsm_d.sh  = rdata_i;
                                fsm_d.low = ~rdata_i[BYTE_W-1];
                                ptr_inc_o = 1'b1;
                            end
                        end
                    end
                end
                ST_RD: begin
                    if (scl_rise_i) begin
                        fsm_d.cnt = fsm_q.cnt + CNT_W'(1);
                        if (fsm_q.cnt == LAST_BIT) begin
                            fsm_d.st = ST_RDACK;
                        end
                    end else if (scl_fall_i) begin
                        fsm_d.sh  = {fsm_q.sh[BYTE_W-2:0], 1'b0};
                        fsm_d.low = ~fsm_q.sh[BYTE_W-2];
                    end
                end
                ST_RDACK: begin
                    if (scl_fall_i && !fsm_q.ackon) begin
                        fsm_d.low   = 1'b0;
                        fsm_d.ackon = 1'b1;
                    end else if (scl_rise_i && fsm_q.ackon) begin
                        fsm_d.hack = ~sda_i;
                    end else if (scl_fall_i && fsm_q.ackon) begin
                        fsm_d.ackon = 1'b0;
                        fsm_d.cnt   = '0;
                        if (fsm_q.hack) begin
                            fsm_d.sh  = rdata_i;
                            fsm_d.low = ~rdata_i[BYTE_W-1];
                            ptr_inc_o = 1'b1;
                            fsm_d.st  = ST_RD;
                        end else begin
                            fsm_d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    fsm_d.low = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q     <= '0;
            fsm_q.st  <= ST_IDLE;
            fsm_q.nxt <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_low_o = fsm_q.low;
    assign we_o      = fsm_q.we;
    assign waddr_o   = fsm_q.waddr;
    assign wdata_o   = fsm_q.wdata;

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> fsm_q.st == ST_ADDR); // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (fsm_q.st == ST_IDLE && !sda_low_o)); // R10
    AST_LOW_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> !scl_i); // R9
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> !we_o); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.st == ST_IDLE |-> !sda_low_o); // R6
endmodule

// File: rtl/rsp_i2c_regport.sv
module rsp_i2c_regport
    import rsp_pkg::*;
#(
    parameter int         PTR_W       = 8,
    parameter logic [3:0] DEV_HI      = 4'b0001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_drive_low_o,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [PTR_W-1:0]   reg_addr_o,
    output logic [BYTE_W-1:0]  reg_wdata_o,
    output logic               reg_we_o,
    input  logic [BYTE_W-1:0]  reg_rdata_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic ptr_load, ptr_inc;
    logic [PTR_W-1:0] ptr_load_val, ptr, waddr;

    rsp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_p),
        .stop_o     (stop_p)
    );

    rsp_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i (ptr_load_val),
        .inc_i      (ptr_inc),
        .ptr_o      (ptr)
    );

    rsp_target_fsm #(.PTR_W(PTR_W), .DEV_HI(DEV_HI)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl_s),
        .sda_i          (sda_s),
        .scl_rise_i     (scl_rise),
        .scl_fall_i     (scl_fall),
        .start_i        (start_p),
        .stop_i         (stop_p),
        .strap_i        (strap_i),
        .ptr_i          (ptr),
        .rdata_i        (reg_rdata_i),
        .sda_low_o      (sda_drive_low_o),
        .ptr_load_o     (ptr_load),
        .ptr_load_val_o (ptr_load_val),
        .ptr_inc_o      (ptr_inc),
        .we_o           (reg_we_o),
        .waddr_o        (waddr),
        .wdata_o        (reg_wdata_o)
    );

    assign reg_addr_o = reg_we_o ? waddr : ptr;

    AST_WRITE_THEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> ptr == reg_addr_o + PTR_W'(1)); // R3
endmodule

// File: tb/tb_rsp_i2c_regport.sv
module tb_rsp_i2c_regport;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WATCHDOG   = 180000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic [2:0] strap = 3'd5;
    logic       drv;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    int r9_viol = 0;
    int drv_seen = 0;
    bit done = 1'b0;
    logic prev_drv = 1'b0;

    logic [7:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus   = sda_h & ~drv;
    assign reg_rdata = mem[reg_addr];

    rsp_i2c_regport dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_h),
        .sda_i           (sda_bus),
        .sda_drive_low_o (drv),
        .strap_i         (strap),
        .reg_addr_o      (reg_addr),
        .reg_wdata_o     (reg_wdata),
        .reg_we_o        (reg_we),
        .reg_rdata_i     (reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            wcount <= wcount + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (drv && !prev_drv && scl_h) r9_viol++;
            if (drv) drv_seen++;
        end
        prev_drv <= drv;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q_wait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; q_wait();
        scl_h = 1'b1; q_wait();
        sda_h = 1'b0; q_wait();
        scl_h = 1'b0; q_wait();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; q_wait();
        scl_h = 1'b1; q_wait();
        sda_h = 1'b1; q_wait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; q_wait();
            scl_h = 1'b1; q_wait(); q_wait();
            scl_h = 1'b0; q_wait();
        end
        sda_h = 1'b1; q_wait();
        scl_h = 1'b1; q_wait();
        acked = !sda_bus; q_wait();
        scl_h = 1'b0; q_wait();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q_wait();
            scl_h = 1'b1; q_wait();
            b[i] = sda_bus; q_wait();
            scl_h = 1'b0;
        end
        q_wait();
        sda_h = !give_ack; q_wait();
        scl_h = 1'b1; q_wait(); q_wait();
        scl_h = 1'b0; q_wait();
        sda_h = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        send_byte({4'b0001, strap, 1'b0}, a); chk("R1 addr ack", a, 1);
        send_byte(p, a); chk("R2 ptr ack", a, 1);
        bus_stop();
    endtask

    initial begin : main
        logic a;
        logic [7:0] b;
        int w0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 reset drive", drv, 0);
        chk("R10 reset we", reg_we, 0);

        // R1: sweep straps and addresses in the 0001/0000 nibble range
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int ad = 8; ad < 16; ad++) begin
                bus_start();
                send_byte({7'(ad), 1'b0}, a);
                bus_stop();
                chk("R1 match sweep", a, (ad == (8 + s)) ? 1 : 0);
            end
        end
        chk("R1 sweep no writes", wcount, 0);
        strap = 3'd5;

        // R2/R3: pointer byte then four data bytes
        bus_start();
        send_byte(8'h1A, a); chk("R1 addr ack", a, 1);
        send_byte(8'h40, a); chk("R2 ptr ack", a, 1);
        for (int k = 0; k < 4; k++) begin
            send_byte(8'(8'h90 + k * 7), a); chk("R3 data ack", a, 1);
        end
        bus_stop();
        chk("R10 stop release", drv, 0);
        chk("R2 pointer byte not stored", wcount, 4);
        for (int k = 0; k < 4; k++) chk("R3 stored", mem[8'h40 + k], 8'(8'h90 + k * 7));
        chk("R3 neighbour untouched", mem[8'h3F], init_val(8'h3F));
        chk("R3 neighbour untouched", mem[8'h44], init_val(8'h44));

        // R4/R6: read two, NACK, clock extra byte
        set_ptr(8'h40);
        bus_start();
        send_byte(8'h1B, a); chk("R1 read addr ack", a, 1);
        recv_byte(1'b1, b); chk("R4 read byte0", b, 8'h90);
        recv_byte(1'b0, b); chk("R4 read byte1", b, 8'h97);
        w0 = drv_seen;
        recv_byte(1'b0, b); chk("R6 released after nack", b, 8'hFF);
        chk("R6 no drive after nack", drv_seen - w0, 0);
        bus_stop();

        // R5: resumes at next unread address
        bus_start();
        send_byte(8'h1B, a); chk("R1 read addr ack", a, 1);
        recv_byte(1'b1, b); chk("R5 resume byte2", b, 8'h9E);
        recv_byte(1'b0, b); chk("R5 resume byte3", b, 8'hA5);
        bus_stop();

        // R7: pointer write, repeated START, read
        bus_start();
        send_byte(8'h1A, a);
        send_byte(8'h41, a); chk("R7 ptr ack", a, 1);
        bus_start();
        send_byte(8'h1B, a); chk("R7 sr addr ack", a, 1);
        recv_byte(1'b0, b); chk("R7 read after sr", b, 8'h97);
        bus_stop();

        // R8: wrap on write and on read
        bus_start();
        send_byte(8'h1A, a);
        send_byte(8'hFE, a);
        send_byte(8'hE0, a); send_byte(8'hE1, a); send_byte(8'hE2, a);
        bus_stop();
        chk("R8 write FE", mem[8'hFE], 8'hE0);
        chk("R8 write FF", mem[8'hFF], 8'hE1);
        chk("R8 write wrap 00", mem[8'h00], 8'hE2);
        set_ptr(8'hFF);
        bus_start();
        send_byte(8'h1B, a);
        recv_byte(1'b1, b); chk("R8 read FF", b, 8'hE1);
        recv_byte(1'b0, b); chk("R8 read wrap 00", b, 8'hE2);
        bus_stop();

        // R1: foreign address ignored, pointer kept (now 0x01)
        w0 = wcount;
        bus_start();
        send_byte(8'h18, a); chk("R1 foreign no ack", a, 0);
        send_byte(8'h10, a); chk("R1 foreign ptr no ack", a, 0);
        send_byte(8'h77, a); chk("R1 foreign data no ack", a, 0);
        bus_stop();
        chk("R1 foreign no write", wcount - w0, 0);
        bus_start();
        send_byte(8'h1B, a);
        recv_byte(1'b0, b); chk("R1 pointer unchanged", b, init_val(1));
        bus_stop();

        chk("R9 drive only while scl low", r9_viol, 0);
        chk("R9 drive exercised", (drv_seen > 0) ? 1 : 0, 1);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule